// File: doc/BRIEF.md
# Timer Channel Counter Clock Gate

This block decides, cycle by cycle, whether the counter of one timer channel may advance. The selected timing source reaches it as a one-cycle tick in the system clock domain. The tick is passed on as a count strobe only while two independent set/reset states are both true: an enable state, which software owns, and a run state, which triggers set. An event that depends on the channel mode can also stop the counter or disable the whole channel.

Software acts through three command strobes: enable, disable and a trigger. Hardware triggers arrive as a parameterised vector. A mode bit picks capture operation or waveform operation. In capture mode, a capture-B load event can act on the channel. In waveform mode, a compare-C match event can act on it. Per-channel option bits select whether each of these events stops the counter, disables the channel, or does neither. The block also reports the enable state, and it derives the direction of the two channel pins from the mode.

Top module: `ckgate_ctrl`

## Requirements
- R1: `cnt_adv_o` is high in a cycle exactly when `tick_i` is high, the enable state is set and the run state is set.
- R2: A `cmd_en_i` pulse sets the enable state from the next cycle on. `en_sts_o` equals the enable state at all times.
- R3: A `cmd_dis_i` pulse clears both the enable state and the run state. If it arrives in the same cycle as `cmd_en_i`, the channel ends up disabled.
- R4: While the channel is enabled, a software trigger or any bit of `hw_trig_i` sets the run state. If a trigger and a stop event arrive in the same cycle, the counter keeps running.
- R5: Triggers and stop events have no effect while the enable state is clear. This includes a trigger in the same cycle as the enabling command. After it is re-enabled, the channel stays stopped until the next trigger.
- R6: In capture mode (`wave_mode_i`=0), `rb_load_i` clears the run state when `opt_stop_rb_i`=1 and disables the channel when `opt_dis_rb_i`=1. `rc_cmp_i` has no effect in this mode.
- R7: In waveform mode (`wave_mode_i`=1), `rc_cmp_i` clears the run state when `opt_stop_rc_i`=1 and disables the channel when `opt_dis_rc_i`=1. `rb_load_i` has no effect in this mode.
- R8: In capture mode, `pin_a_oe_o` and `pin_b_oe_o` are both 0. In waveform mode, `pin_a_oe_o` is 1, and `pin_b_oe_o` is 1 unless `pin_b_trig_i`=1.
- R9: After a synchronous reset, the channel is disabled and stopped, and `en_sts_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle tick of the selected timing source |
| cmd_en_i | input | 1 | Software enable command strobe |
| cmd_dis_i | input | 1 | Software disable command strobe |
| cmd_trig_i | input | 1 | Software trigger strobe |
| hw_trig_i | input | NUM_HW_TRIG | Hardware trigger strobes (synchronized, external, compare) |
| wave_mode_i | input | 1 | 0 = capture mode, 1 = waveform mode |
| rb_load_i | input | 1 | Capture-B load event |
| rc_cmp_i | input | 1 | Compare-C match event |
| opt_stop_rb_i | input | 1 | Stop the counter on a capture-B load |
| opt_dis_rb_i | input | 1 | Disable the channel on a capture-B load |
| opt_stop_rc_i | input | 1 | Stop the counter on a compare-C match |
| opt_dis_rc_i | input | 1 | Disable the channel on a compare-C match |
| pin_b_trig_i | input | 1 | Pin B is selected as the external trigger |
| cnt_adv_o | output | 1 | Counter advance strobe |
| en_sts_o | output | 1 | Enable state status |
| pin_a_oe_o | output | 1 | Pin A drive enable |
| pin_b_oe_o | output | 1 | Pin B drive enable |

## Verification
The bench builds the block with `NUM_HW_TRIG`=4 instead of the default 3. This means the generated trigger-merge chain has one more stage than usual. The directed cases drive the highest-indexed trigger bit on its own, so a break at the end of the chain is caught. With four hardware strobes plus the software trigger, random stimulus often produces a trigger in the same cycle as a stop or disable event. The directed cases also pin down the priority orderings of R3, R4 and R5 one at a time.

// File: rtl/ckgate_pkg.sv
package ckgate_pkg;

  typedef enum logic {
    MODE_CAPTURE = 1'b0,
    MODE_WAVE    = 1'b1
  } chan_mode_e;

  typedef struct packed {
    logic stop_rb;
    logic dis_rb;
    logic stop_rc;
    logic dis_rc;
  } evt_opts_t;

endpackage

// File: rtl/ckgate_evt_decode.sv
module ckgate_evt_decode
  import ckgate_pkg::*;
#(
  parameter int NUM_HW_TRIG = 3
) (
  input  chan_mode_e             mode_i,
  input  evt_opts_t              opts_i,
  input  logic                   rb_load_i,
  input  logic                   rc_cmp_i,
  input  logic                   cmd_dis_i,
  input  logic                   cmd_trig_i,
  input  logic [NUM_HW_TRIG-1:0] hw_trig_i,
  output logic                   dis_evt_o,
  output logic                   stop_evt_o,
  output logic                   trig_evt_o
);

  // merge chain over the hardware trigger strobes
  logic [NUM_HW_TRIG:0] trig_chain;
  assign trig_chain[0] = cmd_trig_i;

  for (genvar g = 0; g < NUM_HW_TRIG; g++) begin : g_trig_merge
    assign trig_chain[g+1] = trig_chain[g] | hw_trig_i[g];
  end

  logic rb_live;
  logic rc_live;

  always_comb begin
    rb_live    = (mode_i == MODE_CAPTURE) && rb_load_i;
    rc_live    = (mode_i == MODE_WAVE)    && rc_cmp_i;
    dis_evt_o  = cmd_dis_i
               | (rb_live & opts_i.dis_rb)
               | (rc_live & opts_i.dis_rc);
    stop_evt_o = (rb_live & opts_i.stop_rb)
               | (rc_live & opts_i.stop_rc);
    trig_evt_o = trig_chain[NUM_HW_TRIG];
  end

endmodule

// File: rtl/ckgate_sr_state.sv
module ckgate_sr_state #(
  parameter bit CLR_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  logic q_d;

  if (CLR_WINS) begin : g_clr_first
    always_comb begin
      if (clr_i)      q_d = 1'b0;
      else if (set_i) q_d = 1'b1;
      else            q_d = q_o;
    end
  end else begin : g_set_first
    always_comb begin
      if (set_i)      q_d = 1'b1;
      else if (clr_i) q_d = 1'b0;
      else            q_d = q_o;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= q_d;
  end

endmodule

// File: rtl/ckgate_ctrl.sv
module ckgate_ctrl
  import ckgate_pkg::*;
#(
  parameter int NUM_HW_TRIG = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick_i,
  input  logic                   cmd_en_i,
  input  logic                   cmd_dis_i,
  input  logic                   cmd_trig_i,
  input  logic [NUM_HW_TRIG-1:0] hw_trig_i,
  input  logic                   wave_mode_i,
  input  logic                   rb_load_i,
  input  logic                   rc_cmp_i,
  input  logic                   opt_stop_rb_i,
  input  logic                   opt_dis_rb_i,
  input  logic                   opt_stop_rc_i,
  input  logic                   opt_dis_rc_i,
  input  logic                   pin_b_trig_i,
  output logic                   cnt_adv_o,
  output logic                   en_sts_o,
  output logic                   pin_a_oe_o,
  output logic                   pin_b_oe_o
);

  chan_mode_e mode;
  evt_opts_t  opts;
  logic       dis_evt;
  logic       stop_evt;
  logic       trig_evt;
  logic       en_q;
  logic       run_q;
  logic       run_set;
  logic       run_clr;

  assign mode = chan_mode_e'(wave_mode_i);

  always_comb begin
    opts.stop_rb = opt_stop_rb_i;
    opts.dis_rb  = opt_dis_rb_i;
    opts.stop_rc = opt_stop_rc_i;
    opts.dis_rc  = opt_dis_rc_i;
  end

  ckgate_evt_decode #(
    .NUM_HW_TRIG (NUM_HW_TRIG)
  ) u_decode (
    .mode_i     (mode),
    .opts_i     (opts),
    .rb_load_i  (rb_load_i),
    .rc_cmp_i   (rc_cmp_i),
    .cmd_dis_i  (cmd_dis_i),
    .cmd_trig_i (cmd_trig_i),
    .hw_trig_i  (hw_trig_i),
    .dis_evt_o  (dis_evt),
    .stop_evt_o (stop_evt),
    .trig_evt_o (trig_evt)
  );

  // enable state: a disable from any source beats the enable command
  ckgate_sr_state #(
    .CLR_WINS (1'b1)
  ) u_en_state (
    .clk   (clk),
    .rst   (rst),
    .set_i (cmd_en_i),
    .clr_i (dis_evt),
    .q_o   (en_q)
  );

  // run state: start/stop are honoured only while already enabled;
  // a trigger beats a stop, a disable beats everything
  assign run_set = trig_evt & en_q & ~dis_evt;
  assign run_clr = dis_evt | (stop_evt & en_q);

  ckgate_sr_state #(
    .CLR_WINS (1'b0)
  ) u_run_state (
    .clk   (clk),
    .rst   (rst),
    .set_i (run_set),
    .clr_i (run_clr),
    .q_o   (run_q)
  );

  assign cnt_adv_o  = tick_i & en_q & run_q;
  assign en_sts_o   = en_q;
  assign pin_a_oe_o = (mode == MODE_WAVE);
  assign pin_b_oe_o = (mode == MODE_WAVE) && !pin_b_trig_i;

endmodule

// File: rtl/ckgate_chk.sv
module ckgate_chk (
  input logic clk,
  input logic rst,
  input logic tick_i,
  input logic cmd_en_i,
  input logic cmd_dis_i,
  input logic wave_mode_i,
  input logic pin_b_trig_i,
  input logic dis_evt,
  input logic run_q,
  input logic cnt_adv_o,
  input logic en_sts_o,
  input logic pin_a_oe_o,
  input logic pin_b_oe_o
);

  p_adv_gated_r1: assert property (@(posedge clk) disable iff (rst)
    cnt_adv_o |-> (tick_i && en_sts_o));

  p_enable_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_en_i && !dis_evt) |=> en_sts_o);

  p_disable_wins_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_dis_i |=> (!en_sts_o && !run_q));

  p_no_run_when_off_r5: assert property (@(posedge clk) disable iff (rst)
    !en_sts_o |=> !run_q);

  p_capture_pins_r8: assert property (@(posedge clk) disable iff (rst)
    !wave_mode_i |-> (!pin_a_oe_o && !pin_b_oe_o));

  p_wave_pins_r8: assert property (@(posedge clk) disable iff (rst)
    wave_mode_i |-> (pin_a_oe_o && (pin_b_oe_o == !pin_b_trig_i)));

  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> (!en_sts_o && !run_q));

endmodule

bind ckgate_ctrl ckgate_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .tick_i       (tick_i),
  .cmd_en_i     (cmd_en_i),
  .cmd_dis_i    (cmd_dis_i),
  .wave_mode_i  (wave_mode_i),
  .pin_b_trig_i (pin_b_trig_i),
  .dis_evt      (dis_evt),
  .run_q        (run_q),
  .cnt_adv_o    (cnt_adv_o),
  .en_sts_o     (en_sts_o),
  .pin_a_oe_o   (pin_a_oe_o),
  .pin_b_oe_o   (pin_b_oe_o)
);

// File: tb/ckgate_ctrl_tb_top.sv
`timescale 1ns/1ps
module ckgate_ctrl_tb_top;

  localparam int NHT = 4;

  logic           clk = 1'b0;
  logic           rst;
  logic           tick_i, cmd_en_i, cmd_dis_i, cmd_trig_i;
  logic [NHT-1:0] hw_trig_i;
  logic           wave_mode_i, rb_load_i, rc_cmp_i;
  logic           opt_stop_rb_i, opt_dis_rb_i, opt_stop_rc_i, opt_dis_rc_i;
  logic           pin_b_trig_i;
  logic           cnt_adv_o, en_sts_o, pin_a_oe_o, pin_b_oe_o;

  int n_chk = 0;
  int n_bad = 0;
  bit m_en  = 1'b0;
  bit m_run = 1'b0;

  always #2 clk = ~clk;

  ckgate_ctrl #(.NUM_HW_TRIG(NHT)) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick_i),
    .cmd_en_i(cmd_en_i), .cmd_dis_i(cmd_dis_i), .cmd_trig_i(cmd_trig_i),
    .hw_trig_i(hw_trig_i), .wave_mode_i(wave_mode_i),
    .rb_load_i(rb_load_i), .rc_cmp_i(rc_cmp_i),
    .opt_stop_rb_i(opt_stop_rb_i), .opt_dis_rb_i(opt_dis_rb_i),
    .opt_stop_rc_i(opt_stop_rc_i), .opt_dis_rc_i(opt_dis_rc_i),
    .pin_b_trig_i(pin_b_trig_i),
    .cnt_adv_o(cnt_adv_o), .en_sts_o(en_sts_o),
    .pin_a_oe_o(pin_a_oe_o), .pin_b_oe_o(pin_b_oe_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // reference next-state rules, written from the requirements
  function automatic bit f_dis();
    return cmd_dis_i
        || (!wave_mode_i && rb_load_i && opt_dis_rb_i)
        || ( wave_mode_i && rc_cmp_i  && opt_dis_rc_i);
  endfunction

  function automatic bit f_stop();
    return (!wave_mode_i && rb_load_i && opt_stop_rb_i)
        || ( wave_mode_i && rc_cmp_i  && opt_stop_rc_i);
  endfunction

  function automatic bit f_trig();
    return cmd_trig_i || (hw_trig_i != '0);
  endfunction

  task automatic quiet();
    cmd_en_i = 0; cmd_dis_i = 0; cmd_trig_i = 0; hw_trig_i = '0;
    rb_load_i = 0; rc_cmp_i = 0;
  endtask

  // one clock edge, with the model advanced alongside the design
  task automatic step();
    bit ne, nr;
    bit d, s, t;
    d = f_dis(); s = f_stop(); t = f_trig();
    if (rst) begin
      ne = 0; nr = 0;
    end else begin
      ne = d ? 1'b0 : (cmd_en_i ? 1'b1 : m_en);
      if (d)               nr = 0;
      else if (!m_en)      nr = m_run;
      else if (t)          nr = 1;
      else if (s)          nr = 0;
      else                 nr = m_run;
    end
    @(posedge clk);
    m_en = ne; m_run = nr;
    #1;
  endtask

  // directed: apply pulses for one edge, then check state with tick high
  task automatic pulse_chk(input string tag, input logic exp_en, input logic exp_adv);
    step();
    quiet();
    #0.5;
    chk(tag, en_sts_o, exp_en);
    chk(tag, cnt_adv_o, exp_adv);
  endtask

  initial begin
    #20000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c1c));
    quiet();
    rst = 1; tick_i = 1; wave_mode_i = 0; pin_b_trig_i = 0;
    opt_stop_rb_i = 0; opt_dis_rb_i = 0; opt_stop_rc_i = 0; opt_dis_rc_i = 0;
    step(); step();
    rst = 0;
    #0.5;
    chk("R9 reset status", en_sts_o, 1'b0);
    chk("R9 reset no advance", cnt_adv_o, 1'b0);

    // pins
    chk("R8 capture pin A", pin_a_oe_o, 1'b0);
    chk("R8 capture pin B", pin_b_oe_o, 1'b0);

    // trigger while disabled is ignored
    cmd_trig_i = 1;            pulse_chk("R5 trig while off", 0, 0);
    cmd_en_i = 1; cmd_trig_i = 1; pulse_chk("R5 trig with enable", 1, 0);
    cmd_trig_i = 1;            pulse_chk("R4 sw trigger", 1, 1);
    tick_i = 0; #0.5;
    chk("R1 no tick no advance", cnt_adv_o, 1'b0);
    tick_i = 1;
    cmd_en_i = 1; cmd_dis_i = 1; pulse_chk("R3 disable beats enable", 0, 0);
    cmd_en_i = 1;              pulse_chk("R5 stays stopped on re-enable", 1, 0);
    hw_trig_i[NHT-1] = 1;      pulse_chk("R4 top hw trigger", 1, 1);

    // capture mode events
    opt_stop_rc_i = 1; opt_dis_rc_i = 1;
    rc_cmp_i = 1;              pulse_chk("R6 rc ignored in capture", 1, 1);
    opt_stop_rb_i = 1;
    rb_load_i = 1; hw_trig_i[0] = 1; pulse_chk("R4 trigger beats stop", 1, 1);
    rb_load_i = 1;             pulse_chk("R6 stop on rb", 1, 0);
    rb_load_i = 1; cmd_trig_i = 1; opt_stop_rb_i = 0;
    pulse_chk("R6 no stop when option clear", 1, 1);
    opt_dis_rb_i = 1;
    rb_load_i = 1;             pulse_chk("R6 disable on rb", 0, 0);
    rb_load_i = 1; cmd_en_i = 1; pulse_chk("R3 event disable beats enable", 0, 0);
    opt_dis_rb_i = 0; opt_stop_rb_i = 1;

    // waveform mode events
    wave_mode_i = 1; #0.5;
    chk("R8 wave pin A", pin_a_oe_o, 1'b1);
    chk("R8 wave pin B out", pin_b_oe_o, 1'b1);
    pin_b_trig_i = 1; #0.5;
    chk("R8 wave pin B trigger", pin_b_oe_o, 1'b0);
    pin_b_trig_i = 0;
    opt_dis_rb_i = 1;
    cmd_en_i = 1;              pulse_chk("R2 enable in wave", 1, 0);
    cmd_trig_i = 1;            pulse_chk("R4 start in wave", 1, 1);
    rb_load_i = 1;             pulse_chk("R7 rb ignored in wave", 1, 1);
    opt_dis_rc_i = 0;
    rc_cmp_i = 1;              pulse_chk("R7 stop on rc", 1, 0);
    cmd_trig_i = 1;            pulse_chk("R4 restart", 1, 1);
    opt_dis_rc_i = 1;
    rc_cmp_i = 1;              pulse_chk("R7 disable on rc", 0, 0);
    cmd_en_i = 1; pulse_chk("R2 enable again", 1, 0);
    cmd_trig_i = 1; pulse_chk("R4 start again", 1, 1);
    cmd_dis_i = 1; cmd_trig_i = 1; pulse_chk("R3 disable clears run", 0, 0);

    // random phase against the reference rules
    for (int i = 0; i < 4000; i++) begin
      rst           = ($urandom_range(0, 199) == 0);
      tick_i        = $urandom_range(0, 1);
      cmd_en_i      = ($urandom_range(0, 5) == 0);
      cmd_dis_i     = ($urandom_range(0, 11) == 0);
      cmd_trig_i    = ($urandom_range(0, 7) == 0);
      for (int k = 0; k < NHT; k++) hw_trig_i[k] = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 63) == 0) wave_mode_i = ~wave_mode_i;
      rb_load_i     = ($urandom_range(0, 5) == 0);
      rc_cmp_i      = ($urandom_range(0, 5) == 0);
      opt_stop_rb_i = $urandom_range(0, 1);
      opt_dis_rb_i  = ($urandom_range(0, 3) == 0);
      opt_stop_rc_i = $urandom_range(0, 1);
      opt_dis_rc_i  = ($urandom_range(0, 3) == 0);
      pin_b_trig_i  = $urandom_range(0, 1);
      #0.5;
      chk("R1 random advance", cnt_adv_o, tick_i & m_en & m_run);
      chk("R2 random status", en_sts_o, m_en);
      chk("R8 random pin A", pin_a_oe_o, wave_mode_i);
      chk("R8 random pin B", pin_b_oe_o, wave_mode_i & ~pin_b_trig_i);
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule